// File: doc/BRIEF.md
# Host Slave Data Bus Buffer Interface

This block is the slave end of an 8-bit host bus that runs independently of the local clock. It holds three registers: an input buffer that the host fills, an output buffer that the local core fills, and a status byte. The host selects the block with an active-low chip select. It writes bytes with an active-low write strobe. With an active-low read strobe and an address line A0 it picks either the output buffer or the status byte. Each host write records A0 as a command/data marker. Full flags tell each side when a byte is waiting for it.

The host pins pass through a synchronizer into a small host-cycle state machine. Its states are `H_IDLE`, `H_WRITE`, `H_RD_DATA` and `H_RD_STAT`. The transitions are:

- **select-write:** `H_IDLE` to `H_WRITE`.
- **select-read:** `H_IDLE` to `H_RD_DATA` when A0 is low, or to `H_RD_STAT` when A0 is high.
- **strobe-end:** any active state back to `H_IDLE` when the strobe or the select is seen released.

Flag changes caused by the host happen only on the strobe-end transition. While the machine sits in `H_RD_STAT`, the status byte the host sees is frozen. Local status writes made during that time are parked and applied once the read ends.

Top module: `dbb_if`

## Requirements
- R1: After synchronous reset, the input-full, output-full, F0 and F1 flags and the four user status bits are all 0, so a status read returns 0x00.
- R2: A selected host write loads the input buffer and sets input-full. Input-full stays 0 for as long as the write strobe is held low and rises only after the strobe is released.
- R3: The A0 level of each host write is stored as F1 (A0=1 command sets F1, A0=0 data clears F1). The status byte layout is bit 7..4 user bits, bit 3 F1, bit 2 F0, bit 1 input-full, bit 0 output-full.
- R4: A local read strobe clears input-full. If it lands in the same cycle as a host write completing, input-full stays 1 and the buffer holds the new byte.
- R5: A local load sets output-full. A host read with A0=0 returns the output buffer, and output-full clears only after that read strobe is released.
- R6: If a local load lands in the same cycle as a host data read completing, output-full stays 1 and the buffer holds the newly loaded byte.
- R7: A host read with A0=1 returns the status byte and leaves output-full unchanged.
- R8: A local status write replaces bits 7..4 only. A local F0 write changes bit 2 only.
- R9: While a host status read is in progress, the byte it returns does not change, whether from local status or F0 writes or from flag changes. Status writes made during the read take effect after it ends.
- R10: With chip select high, a write strobe leaves the input buffer and input-full unchanged.
- R11: The data bus output enable is 1 only while chip select and the read strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_a0 | input | 1 | Host address: 0 data, 1 command/status |
| hst_din | input | 8 | Host write data |
| hst_dout | output | 8 | Host read data |
| hst_doe | output | 1 | Three-state enable for the host data bus |
| loc_obuf_wr | input | 1 | Local load strobe for the output buffer |
| loc_obuf_data | input | 8 | Byte to load into the output buffer |
| loc_ibuf_rd | input | 1 | Local read strobe, clears input-full |
| loc_ibuf_data | output | 8 | Input buffer contents |
| loc_sts_wr | input | 1 | Local write of user status bits |
| loc_sts_hi | input | 4 | New value for status bits 7..4 |
| loc_f0_wr | input | 1 | Local write of F0 |
| loc_f0_val | input | 1 | New F0 value |
| loc_ibf | output | 1 | Input-full flag |
| loc_obf | output | 1 | Output-full flag |
| loc_f1 | output | 1 | Command/data flag F1 |

## Verification
Two pairs of actions can meet in one clock: a host strobe-end that sets or clears a full flag, and a local strobe that does the opposite to the same flag. The bench releases the host strobe on a falling clock edge and counts two synchronizer edges. It then pulses the local load or local read in the exact cycle in which the state machine takes its strobe-end transition. The result is judged by the flag after the next edge and by the buffer byte the host or core then reads back, which must be the newer byte with the flag still set.

// File: rtl/dbb_pkg.sv
package dbb_pkg;

    localparam int DBB_W    = 8;
    localparam int USR_W    = 4;
    localparam int HOST_IFW = DBB_W + 4;

    typedef enum logic [1:0] {
        H_IDLE,
        H_WRITE,
        H_RD_DATA,
        H_RD_STAT
    } host_state_e;

    typedef struct packed {
        logic [USR_W-1:0] usr;
        logic             f1;
        logic             f0;
        logic             ibf;
        logic             obf;
    } dbb_status_t;

endpackage

// File: rtl/dbb_sync.sv
module dbb_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int NST = (STAGES < 1) ? 1 : STAGES;

    logic [W-1:0] pipe [NST];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NST; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < NST; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[NST-1];
endmodule

// File: rtl/dbb_host_fsm.sv
module dbb_host_fsm
    import dbb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_cs,
    input  logic             s_rd,
    input  logic             s_wr,
    input  logic             s_a0,
    input  logic [DBB_W-1:0] s_din,
    output logic             wr_done,
    output logic             wr_a0,
    output logic [DBB_W-1:0] wr_data,
    output logic             rd_data_done,
    output logic             sts_lock
);
    host_state_e state_q, state_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE: begin
                if (s_cs && s_wr)      state_d = H_WRITE;
                else if (s_cs && s_rd) state_d = s_a0 ? H_RD_STAT : H_RD_DATA;
            end
            H_WRITE:   if (!s_wr || !s_cs) state_d = H_IDLE;
            H_RD_DATA: if (!s_rd || !s_cs) state_d = H_IDLE;
            H_RD_STAT: if (!s_rd || !s_cs) state_d = H_IDLE;
            default:   state_d = H_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= H_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_done      = (state_q == H_WRITE)   && (state_d == H_IDLE);
        rd_data_done = (state_q == H_RD_DATA) && (state_d == H_IDLE);
        sts_lock     = (state_q == H_RD_STAT);
    end

    // capture of write byte and A0 while the strobe is seen active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_data <= '0;
            wr_a0   <= 1'b0;
        end else if (s_cs && s_wr) begin
            wr_data <= s_din;
            wr_a0   <= s_a0;
        end
    end

    p_write_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(s_wr));

    p_lock_from_a0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_lock) |-> $past(s_a0) && $past(s_rd));
endmodule

// File: rtl/dbb_status.sv
module dbb_status
    import dbb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             sts_wr,
    input  logic [USR_W-1:0] sts_hi,
    input  logic             f0_wr,
    input  logic             f0_val,
    input  logic             ibf,
    input  logic             obf,
    input  logic             f1,
    output dbb_status_t      view
);
    logic [USR_W-1:0] usr_q, pend_usr;
    logic             pend_usr_v;
    logic             f0_q, pend_f0, pend_f0_v;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr_q      <= '0;
            pend_usr   <= '0;
            pend_usr_v <= 1'b0;
            f0_q       <= 1'b0;
            pend_f0    <= 1'b0;
            pend_f0_v  <= 1'b0;
            view       <= '0;
        end else if (lock) begin
            if (sts_wr) begin
                pend_usr   <= sts_hi;
                pend_usr_v <= 1'b1;
            end
            if (f0_wr) begin
                pend_f0   <= f0_val;
                pend_f0_v <= 1'b1;
            end
        end else begin
            if (sts_wr)          usr_q <= sts_hi;
            else if (pend_usr_v) usr_q <= pend_usr;
            if (f0_wr)           f0_q  <= f0_val;
            else if (pend_f0_v)  f0_q  <= pend_f0;
            pend_usr_v <= 1'b0;
            pend_f0_v  <= 1'b0;
            view       <= '{usr: usr_q, f1: f1, f0: f0_q, ibf: ibf, obf: obf};
        end
    end

    p_view_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock && $past(lock) |-> $stable(view));

    p_pend_applied_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lock && pend_usr_v && !sts_wr |=> usr_q == $past(pend_usr));
endmodule

// File: rtl/dbb_if.sv
module dbb_if
    import dbb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_cs_n,
    input  logic             hst_rd_n,
    input  logic             hst_wr_n,
    input  logic             hst_a0,
    input  logic [7:0]       hst_din,
    output logic [7:0]       hst_dout,
    output logic             hst_doe,
    input  logic             loc_obuf_wr,
    input  logic [7:0]       loc_obuf_data,
    input  logic             loc_ibuf_rd,
    output logic [7:0]       loc_ibuf_data,
    input  logic             loc_sts_wr,
    input  logic [3:0]       loc_sts_hi,
    input  logic             loc_f0_wr,
    input  logic             loc_f0_val,
    output logic             loc_ibf,
    output logic             loc_obf,
    output logic             loc_f1
);
    logic [HOST_IFW-1:0] raw_pins, syn_pins;
    logic                s_cs, s_rd, s_wr, s_a0;
    logic [DBB_W-1:0]    s_din;
    logic                wr_done, wr_a0, rd_data_done, sts_lock;
    logic [DBB_W-1:0]    wr_data;
    dbb_status_t         sts_view;

    logic [DBB_W-1:0]    ibuf_q, obuf_q;
    logic                ibf_q, obf_q, f1_q;

    assign raw_pins = {~hst_cs_n, ~hst_rd_n, ~hst_wr_n, hst_a0, hst_din};

    dbb_sync #(.W(HOST_IFW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_pins),
        .q    (syn_pins)
    );

    assign {s_cs, s_rd, s_wr, s_a0, s_din} = syn_pins;

    dbb_host_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_cs        (s_cs),
        .s_rd        (s_rd),
        .s_wr        (s_wr),
        .s_a0        (s_a0),
        .s_din       (s_din),
        .wr_done     (wr_done),
        .wr_a0       (wr_a0),
        .wr_data     (wr_data),
        .rd_data_done(rd_data_done),
        .sts_lock    (sts_lock)
    );

    dbb_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .lock  (sts_lock),
        .sts_wr(loc_sts_wr),
        .sts_hi(loc_sts_hi),
        .f0_wr (loc_f0_wr),
        .f0_val(loc_f0_val),
        .ibf   (ibf_q),
        .obf   (obf_q),
        .f1    (f1_q),
        .view  (sts_view)
    );

    // buffers and flags: the newer event wins a same-cycle collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibuf_q <= '0;
            ibf_q  <= 1'b0;
            f1_q   <= 1'b0;
            obuf_q <= '0;
            obf_q  <= 1'b0;
        end else begin
            if (wr_done) begin
                ibuf_q <= wr_data;
                ibf_q  <= 1'b1;
                f1_q   <= wr_a0;
            end else if (loc_ibuf_rd) begin
                ibf_q  <= 1'b0;
            end
            if (loc_obuf_wr) begin
                obuf_q <= loc_obuf_data;
                obf_q  <= 1'b1;
            end else if (rd_data_done) begin
                obf_q  <= 1'b0;
            end
        end
    end

    assign hst_doe       = !hst_cs_n && !hst_rd_n;
    assign hst_dout      = !hst_doe ? '0 : (hst_a0 ? DBB_W'(sts_view) : obuf_q);
    assign loc_ibuf_data = ibuf_q;
    assign loc_ibf       = ibf_q;
    assign loc_obf       = obf_q;
    assign loc_f1        = f1_q;

    p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> loc_ibf && loc_ibuf_data == $past(wr_data));

    p_obf_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loc_obuf_wr && rd_data_done |=> loc_obf);

    p_obf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_done && !loc_obuf_wr |=> !loc_obf);
endmodule

// File: tb/dbb_if_tb.sv
module dbb_if_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_cs_n = 1'b1, hst_rd_n = 1'b1, hst_wr_n = 1'b1, hst_a0 = 1'b0;
    logic [7:0] hst_din = '0;
    logic [7:0] hst_dout;
    logic       hst_doe;
    logic       loc_obuf_wr = 1'b0, loc_ibuf_rd = 1'b0, loc_sts_wr = 1'b0;
    logic       loc_f0_wr = 1'b0, loc_f0_val = 1'b0;
    logic [7:0] loc_obuf_data = '0;
    logic [3:0] loc_sts_hi = '0;
    logic [7:0] loc_ibuf_data;
    logic       loc_ibf, loc_obf, loc_f1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit mon_req = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    dbb_if u_dut (
        .clk(clk), .rst_n(rst_n),
        .hst_cs_n(hst_cs_n), .hst_rd_n(hst_rd_n), .hst_wr_n(hst_wr_n),
        .hst_a0(hst_a0), .hst_din(hst_din), .hst_dout(hst_dout), .hst_doe(hst_doe),
        .loc_obuf_wr(loc_obuf_wr), .loc_obuf_data(loc_obuf_data),
        .loc_ibuf_rd(loc_ibuf_rd), .loc_ibuf_data(loc_ibuf_data),
        .loc_sts_wr(loc_sts_wr), .loc_sts_hi(loc_sts_hi),
        .loc_f0_wr(loc_f0_wr), .loc_f0_val(loc_f0_val),
        .loc_ibf(loc_ibf), .loc_obf(loc_obf), .loc_f1(loc_f1)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops expected host-read bytes and compares on a falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (mon_req) begin
                string t;
                logic [7:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " doe"}, {7'd0, hst_doe}, 8'd1);
                chk(t, hst_dout, e);
                mon_req = 1'b0;
            end
        end
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sb_expect(input logic [7:0] e, input string tag);
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        mon_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd_begin(input logic a0);
        @(negedge clk);
        hst_cs_n = 1'b0; hst_a0 = a0; hst_rd_n = 1'b0;
        waitn(4);
    endtask

    task automatic rd_end();
        hst_rd_n = 1'b1;
        @(negedge clk);
        hst_cs_n = 1'b1;
        waitn(4);
    endtask

    task automatic host_read(input logic a0, input logic [7:0] e, input string tag);
        rd_begin(a0);
        sb_expect(e, tag);
        rd_end();
    endtask

    task automatic host_write(input logic cs, input logic a0, input logic [7:0] d);
        @(negedge clk);
        hst_cs_n = !cs; hst_a0 = a0; hst_din = d; hst_wr_n = 1'b0;
        waitn(4);
        hst_wr_n = 1'b1;
        @(negedge clk);
        hst_cs_n = 1'b1;
        waitn(4);
    endtask

    task automatic loc_load(input logic [7:0] d);
        @(negedge clk);
        loc_obuf_wr = 1'b1; loc_obuf_data = d;
        @(negedge clk);
        loc_obuf_wr = 1'b0;
        waitn(2);
    endtask

    task automatic loc_read();
        @(negedge clk);
        loc_ibuf_rd = 1'b1;
        @(negedge clk);
        loc_ibuf_rd = 1'b0;
        waitn(2);
    endtask

    task automatic loc_status(input logic [3:0] hi);
        @(negedge clk);
        loc_sts_wr = 1'b1; loc_sts_hi = hi;
        @(negedge clk);
        loc_sts_wr = 1'b0;
    endtask

    task automatic loc_f0(input logic v);
        @(negedge clk);
        loc_f0_wr = 1'b1; loc_f0_val = v;
        @(negedge clk);
        loc_f0_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        waitn(3);
        rst_n = 1'b1;
        waitn(2);

        // R1 reset state
        chk("R1 ibf", {7'd0, loc_ibf}, 8'd0);
        chk("R1 obf", {7'd0, loc_obf}, 8'd0);
        chk("R1 f1",  {7'd0, loc_f1},  8'd0);
        host_read(1'b1, 8'h00, "R1 status");

        // R11 output enable
        @(negedge clk); hst_cs_n = 1'b1; hst_rd_n = 1'b0;
        @(negedge clk); chk("R11 doe cs high", {7'd0, hst_doe}, 8'd0);
        hst_cs_n = 1'b0; hst_rd_n = 1'b1;
        @(negedge clk); chk("R11 doe rd high", {7'd0, hst_doe}, 8'd0);
        hst_cs_n = 1'b1;
        waitn(4);

        // R2 IBF waits for trailing edge
        @(negedge clk);
        hst_cs_n = 1'b0; hst_a0 = 1'b0; hst_din = 8'hA5; hst_wr_n = 1'b0;
        waitn(6);
        chk("R2 ibf during strobe", {7'd0, loc_ibf}, 8'd0);
        hst_wr_n = 1'b1;
        @(negedge clk); hst_cs_n = 1'b1;
        waitn(4);
        chk("R2 ibf after", {7'd0, loc_ibf}, 8'd1);
        chk("R2 ibuf", loc_ibuf_data, 8'hA5);
        chk("R3 f1 data", {7'd0, loc_f1}, 8'd0);
        host_read(1'b1, 8'h02, "R3 status data write");

        // R4 local read, R3 command write
        loc_read();
        chk("R4 ibf cleared", {7'd0, loc_ibf}, 8'd0);
        host_write(1'b1, 1'b1, 8'h3C);
        chk("R3 f1 command", {7'd0, loc_f1}, 8'd1);
        host_read(1'b1, 8'h0A, "R3 status command write");

        // R10 deselected write ignored
        loc_read();
        host_write(1'b0, 1'b0, 8'h77);
        chk("R10 ibf", {7'd0, loc_ibf}, 8'd0);
        chk("R10 ibuf", loc_ibuf_data, 8'h3C);

        // R5 / R7
        loc_load(8'h5A);
        chk("R5 obf set", {7'd0, loc_obf}, 8'd1);
        host_read(1'b1, 8'h09, "R7 status");
        chk("R7 obf kept", {7'd0, loc_obf}, 8'd1);
        rd_begin(1'b0);
        sb_expect(8'h5A, "R5 data read");
        chk("R5 obf mid-read", {7'd0, loc_obf}, 8'd1);
        rd_end();
        chk("R5 obf cleared", {7'd0, loc_obf}, 8'd0);

        // R8 status nibble and F0
        loc_status(4'hF);
        loc_f0(1'b1);
        waitn(3);
        host_read(1'b1, 8'hFC, "R8 status");

        // R9 lock-out
        rd_begin(1'b1);
        sb_expect(8'hFC, "R9 before");
        loc_status(4'h5);
        loc_f0(1'b0);
        loc_load(8'h11);
        chk("R9 obf live", {7'd0, loc_obf}, 8'd1);
        sb_expect(8'hFC, "R9 frozen");
        rd_end();
        host_read(1'b1, 8'h59, "R9 pending applied");
        host_read(1'b0, 8'h11, "R5 second read");

        // R6 collision: load with data-read end
        loc_load(8'h22);
        rd_begin(1'b0);
        sb_expect(8'h22, "R6 first");
        hst_rd_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); loc_obuf_wr = 1'b1; loc_obuf_data = 8'h33;
        @(negedge clk); loc_obuf_wr = 1'b0; hst_cs_n = 1'b1;
        waitn(3);
        chk("R6 obf kept", {7'd0, loc_obf}, 8'd1);
        host_read(1'b0, 8'h33, "R6 new byte");

        // R4 collision: local read with write end
        host_write(1'b1, 1'b0, 8'h44);
        @(negedge clk);
        hst_cs_n = 1'b0; hst_a0 = 1'b0; hst_din = 8'h66; hst_wr_n = 1'b0;
        waitn(4);
        hst_wr_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); loc_ibuf_rd = 1'b1;
        @(negedge clk); loc_ibuf_rd = 1'b0; hst_cs_n = 1'b1;
        waitn(3);
        chk("R4 ibf kept", {7'd0, loc_ibf}, 8'd1);
        chk("R4 new byte", loc_ibuf_data, 8'h66);
        loc_read();
        chk("R4 ibf final", {7'd0, loc_ibf}, 8'd0);

        waitn(4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule